// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel. A register interface hands it an initial count, a mode code and a number-format flag through a one-cycle load strobe. The channel then counts on each cycle where the clock-enable input is high. It drives one output pin whose waveform depends on the selected mode: interrupt on terminal count, retriggerable one-shot, rate generator, square wave, or a software or hardware triggered strobe. The count runs either in plain binary or in packed decimal (four digits of four bits each). An initial count of zero means one full turn of the counter.

A gate input controls the channel. In the gated modes a low gate pauses the count. In the triggered modes a rising gate edge restarts the count from the stored initial value. The live count value and the output level are always visible on the ports. Bus decoding, byte sequencing and read latching belong to the surrounding logic.

Top module: `pit_channel`

## Requirements
- R1: After reset the count output is 0, the output pin is low, and no tick changes the count until a value is loaded.
- R2: A load strobe shows the new initial count on the count output in the next cycle. The first tick after it starts counting without decrementing, and each later tick in which counting is allowed subtracts one.
- R3: In binary mode (format flag 0) a decrement of 0 gives 0xFFFF. An initial count of 0 reaches terminal count after 65536 decrementing ticks.
- R4: In decimal mode (format flag 1) every nibble is one decimal digit and borrows to the next digit. A decrement of 0x0000 gives 0x9999, and an initial count of 0 reaches terminal count after 10000 ticks.
- R5: In modes 0 and 1 the output is low from the start of counting until the count first reaches 0. It then stays high while the counter keeps wrapping, until the next load or restart.
- R6: Mode code 2 is periodic. The output goes low exactly while the count is 1, and the next tick reloads the initial count.
- R7: Mode code 3 is periodic with a square-wave output. For an initial count N the output is high for the first (N+1)/2 ticks of each period and low for the rest.
- R8: In modes 4 and 5 the output is high and goes low for one tick only on the first arrival at 0 after a load or restart. Later wraps through 0 leave it high.
- R9: Once loaded and before counting starts, the output is low in mode 0 and high in every other mode.
- R10: In modes 1, 2, 3 and 5, a tick that sees the gate high after a tick that saw it low reloads the initial count and returns to the not-started state. Counting starts on the following tick.
- R11: In modes 0, 2, 3 and 4 a low gate holds the count unchanged. In modes 2 and 3 a low gate also forces the output high.
- R12: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R13: A load strobe in the same cycle as a tick or a gate edge wins. The count takes the loaded value, a pending output pulse is dropped, and counting starts one tick later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one tick per cycle high |
| gate_in | input | 1 | Gate level |
| load_stb | input | 1 | One-cycle strobe that captures a new setting |
| load_value | input | 16 | Initial count, binary or packed decimal |
| load_mode | input | 3 | Mode code 0..7 |
| load_bcd | input | 1 | 1 selects decimal counting |
| count_o | output | 16 | Live count value |
| out_o | output | 1 | Output pin level |

## Verification
Two pairs of events can land in the same cycle. A load strobe can coincide with a counting tick. A load strobe can also coincide with a gate rising edge in a triggered mode. The bench provokes the first by driving the strobe and the enable on the same clock edge while a strobe-mode channel sits one tick from terminal count. It provokes the second by raising the gate together with a load in mode 5. Both cases are judged by the count showing the loaded value with no pulse, then holding for the start tick and decrementing from the new value.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC_INT    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } pit_mode_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic pit_mode_e fold_mode(input logic [2:0] code);
    case (code)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return pit_mode_e'(code);
    endcase
  endfunction

  function automatic logic is_periodic(input pit_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic is_retrig(input pit_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STROBE);
  endfunction

  function automatic logic is_gated(input pit_mode_e m);
    return (m == M_TC_INT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SW_STROBE);
  endfunction

endpackage

// File: rtl/pit_seq.sv
module pit_seq
  import pit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_en,
  input  logic      gate_in,
  input  logic      load_stb,
  input  logic [2:0] load_mode,
  input  logic      load_bcd,
  input  logic      count_one,
  output pit_mode_e mode_q,
  output logic      bcd_q,
  output logic      running_q,
  output logic      done_q,
  output logic      pulse_q,
  output logic      restart_ev,
  output logic      start_ev,
  output logic      dec_ev,
  output logic      reload_ev,
  output logic      tc_ev
);

  logic armed_q;
  logic gate_q;
  logic gate_rise;
  logic gate_ok;

  assign gate_rise  = tick_en && gate_in && !gate_q;
  assign restart_ev = !load_stb && gate_rise && is_retrig(mode_q);
  assign start_ev   = !load_stb && !restart_ev && tick_en && armed_q && !running_q;
  assign gate_ok    = gate_in || !is_gated(mode_q);
  assign dec_ev     = !load_stb && !restart_ev && tick_en && running_q && gate_ok;
  assign reload_ev  = dec_ev && is_periodic(mode_q) && count_one;
  assign tc_ev      = dec_ev && !is_periodic(mode_q) && count_one && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_TC_INT;
      bcd_q     <= 1'b0;
      armed_q   <= 1'b0;
      running_q <= 1'b0;
      done_q    <= 1'b0;
      pulse_q   <= 1'b0;
      gate_q    <= 1'b1;
    end else begin
      if (tick_en) gate_q <= gate_in;
      if (load_stb) begin
        mode_q    <= fold_mode(load_mode);
        bcd_q     <= load_bcd;
        armed_q   <= 1'b1;
        running_q <= 1'b0;
        done_q    <= 1'b0;
        pulse_q   <= 1'b0;
      end else if (restart_ev) begin
        running_q <= 1'b0;
        done_q    <= 1'b0;
        pulse_q   <= 1'b0;
      end else begin
        if (start_ev) running_q <= 1'b1;
        if (tc_ev)    done_q    <= 1'b1;
        if (tick_en)  pulse_q   <= tc_ev;
      end
    end
  end

  // R8: the strobe pulse lasts a single tick
  a_r8_one_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && tick_en) |=> !pulse_q);

  // R10: a restart returns to the not-started state
  a_r10_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ev |=> !running_q);

  // R1: nothing counts before the first load
  a_r1_idle_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !running_q && !dec_ev);

endmodule

// File: rtl/pit_count.sv
module pit_count #(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [4*NDIG-1:0] load_value,
  input  logic              bcd_q,
  input  logic              restart_ev,
  input  logic              reload_ev,
  input  logic              dec_ev,
  output logic [4*NDIG-1:0] count_q,
  output logic [4*NDIG-1:0] init_q
);

  localparam int W = 4 * NDIG;

  logic [W-1:0] bin_next;
  logic [W-1:0] bcd_next;
  logic [W-1:0] dec_next;
  logic [NDIG:0] borrow;

  assign bin_next  = count_q - W'(1);
  assign borrow[0] = 1'b1;

  // decimal borrow chain, one stage per digit
  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    logic [3:0] dig;
    assign dig           = count_q[4*g +: 4];
    assign borrow[g+1]   = borrow[g] && (dig == 4'd0);
    assign bcd_next[4*g +: 4] = !borrow[g] ? dig :
                                (dig == 4'd0) ? 4'd9 : dig - 4'd1;
  end

  assign dec_next = bcd_q ? bcd_next : bin_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      init_q  <= '0;
    end else if (load_stb) begin
      count_q <= load_value;
      init_q  <= load_value;
    end else if (restart_ev || reload_ev) begin
      count_q <= init_q;
    end else if (dec_ev) begin
      count_q <= dec_next;
    end
  end

  // R13: the loaded value always appears
  a_r13_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> count_q == $past(load_value));

  // R6: reload and restart bring back the initial count
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_ev || restart_ev) && !load_stb |=> count_q == $past(init_q));

  // R2 / R11: without an event the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb && !restart_ev && !reload_ev && !dec_ev |=> $stable(count_q));

  // R3: binary wrap
  a_r3_bin_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ev && !bcd_q && count_q == '0 |=> count_q == '1);

  // R4: decimal wrap
  a_r4_bcd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ev && bcd_q && count_q == '0 |=> count_q == {NDIG{4'h9}});

endmodule

// File: rtl/pit_wave.sv
module pit_wave
  import pit_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pit_mode_e         mode_q,
  input  logic              bcd_q,
  input  logic              running_q,
  input  logic              done_q,
  input  logic              pulse_q,
  input  logic              gate_in,
  input  logic [4*NDIG-1:0] count_q,
  input  logic [4*NDIG-1:0] init_q,
  output logic              out_o
);

  localparam int W = 4 * NDIG;
  localparam logic [W:0] FULL_BIN = (W+1)'(1) << W;
  localparam logic [W:0] FULL_BCD = (W+1)'(10 ** NDIG);

  // count value in ticks, zero meaning one full turn
  function automatic logic [W:0] ticks_of(input logic [W-1:0] v, input logic dec);
    logic [W:0] acc;
    if (v == '0) return dec ? FULL_BCD : FULL_BIN;
    if (!dec) return {1'b0, v};
    acc = '0;
    for (int i = NDIG - 1; i >= 0; i--)
      acc = acc * (W+1)'(10) + (W+1)'(v[4*i +: 4]);
    return acc;
  endfunction

  logic square_high;
  assign square_high = ticks_of(count_q, bcd_q) > (ticks_of(init_q, bcd_q) >> 1);

  always_comb begin
    case (mode_q)
      M_TC_INT, M_ONESHOT: out_o = running_q ? done_q : (mode_q != M_TC_INT);
      M_RATE:              out_o = !gate_in || !running_q || (count_q != W'(1));
      M_SQUARE:            out_o = !gate_in || !running_q || square_high;
      default:             out_o = !pulse_q;
    endcase
  end

  // R9: level before counting starts
  a_r9_prestart_level: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> (out_o == (mode_q != M_TC_INT)));

  // R11: low gate holds periodic outputs high
  a_r11_gate_high_out: assert property (@(posedge clk) disable iff (!rst_n)
    is_periodic(mode_q) && !gate_in |-> out_o);

  // R5: once terminal count passed, modes 0/1 stay high
  a_r5_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TC_INT || mode_q == M_ONESHOT) && running_q && done_q |-> out_o);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              gate_in,
  input  logic              load_stb,
  input  logic [4*NDIG-1:0] load_value,
  input  logic [2:0]        load_mode,
  input  logic              load_bcd,
  output logic [4*NDIG-1:0] count_o,
  output logic              out_o
);

  localparam int W = 4 * NDIG;

  pit_mode_e    mode_q;
  logic         bcd_q, running_q, done_q, pulse_q;
  logic         restart_ev, start_ev, dec_ev, reload_ev, tc_ev;
  logic [W-1:0] count_q, init_q;
  logic         count_one;

  assign count_one = (count_q == W'(1));
  assign count_o   = count_q;

  pit_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
    .load_stb(load_stb), .load_mode(load_mode), .load_bcd(load_bcd),
    .count_one(count_one), .mode_q(mode_q), .bcd_q(bcd_q),
    .running_q(running_q), .done_q(done_q), .pulse_q(pulse_q),
    .restart_ev(restart_ev), .start_ev(start_ev), .dec_ev(dec_ev),
    .reload_ev(reload_ev), .tc_ev(tc_ev)
  );

  pit_count #(.NDIG(NDIG)) u_count (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_value(load_value),
    .bcd_q(bcd_q), .restart_ev(restart_ev), .reload_ev(reload_ev),
    .dec_ev(dec_ev), .count_q(count_q), .init_q(init_q)
  );

  pit_wave #(.NDIG(NDIG)) u_wave (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .bcd_q(bcd_q),
    .running_q(running_q), .done_q(done_q), .pulse_q(pulse_q),
    .gate_in(gate_in), .count_q(count_q), .init_q(init_q), .out_o(out_o)
  );

  // R2: the start tick never decrements
  a_r2_start_no_dec: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> count_o == $past(count_o));

  // R8: terminal count in strobe modes drives the pin low
  a_r8_tc_low: assert property (@(posedge clk) disable iff (!rst_n)
    tc_ev && (mode_q == M_SW_STROBE || mode_q == M_HW_STROBE) |=> !out_o);

endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate_in = 1'b1;
  logic        load_stb = 1'b0;
  logic [15:0] load_value = '0;
  logic [2:0]  load_mode = '0;
  logic        load_bcd = 1'b0;
  logic [15:0] count_o;
  logic        out_o;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  pit_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
    .load_stb(load_stb), .load_value(load_value), .load_mode(load_mode),
    .load_bcd(load_bcd), .count_o(count_o), .out_o(out_o)
  );

  task automatic check(input string req, input logic [15:0] ec, input logic eo);
    n_checks++;
    if (count_o !== ec || out_o !== eo) begin
      n_errors++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b", req, count_o, out_o, ec, eo);
    end
  endtask

  task automatic tick1();
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
  endtask

  task automatic bulk(input int n);
    @(negedge clk) tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] v, input logic [2:0] m, input logic b);
    @(negedge clk);
    load_stb = 1'b1; load_value = v; load_mode = m; load_bcd = b;
    @(negedge clk) load_stb = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", 16'h0000, 1'b0);
    tick1(); check("R1 no count before load", 16'h0000, 1'b0);
  endtask

  task automatic t_mode0();
    gate_in = 1'b1;
    do_load(16'd3, 3'd0, 1'b0); check("R2 load shows count / R9 mode0 low", 16'd3, 1'b0);
    tick1(); check("R2 start tick holds", 16'd3, 1'b0);
    tick1(); check("R2 decrement", 16'd2, 1'b0);
    tick1(); check("R5 low before tc", 16'd1, 1'b0);
    tick1(); check("R5 high at tc", 16'd0, 1'b1);
    tick1(); check("R3 binary wrap, R5 stays high", 16'hFFFF, 1'b1);
  endtask

  task automatic t_gate_mode0();
    do_load(16'd5, 3'd0, 1'b0);
    gate_in = 1'b0;
    tick1(); check("R11 start with gate low", 16'd5, 1'b0);
    bulk(3);  check("R11 mode0 gate low holds", 16'd5, 1'b0);
    gate_in = 1'b1;
    tick1(); check("R11 resumes on gate high", 16'd4, 1'b0);
  endtask

  task automatic t_mode2();
    do_load(16'd3, 3'd2, 1'b0); check("R9 mode2 high before start", 16'd3, 1'b1);
    tick1(); check("R6 start", 16'd3, 1'b1);
    tick1(); check("R6 count 2", 16'd2, 1'b1);
    tick1(); check("R6 low at 1", 16'd1, 1'b0);
    tick1(); check("R6 reload", 16'd3, 1'b1);
    tick1(); check("R6 second period", 16'd2, 1'b1);
    tick1(); check("R6 low at 1 again", 16'd1, 1'b0);
    @(negedge clk) gate_in = 1'b0;
    @(negedge clk); check("R11 gate low forces high", 16'd1, 1'b1);
    tick1(); check("R11 mode2 count holds", 16'd1, 1'b1);
    @(negedge clk) gate_in = 1'b1;
    tick1(); check("R10 mode2 gate rise reloads", 16'd3, 1'b1);
    tick1(); check("R10 start after restart", 16'd3, 1'b1);
    tick1(); check("R10 counting after restart", 16'd2, 1'b1);
  endtask

  task automatic t_mode3();
    logic exp5 [6] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    logic [15:0] cnt5 [6] = '{16'd5, 16'd4, 16'd3, 16'd2, 16'd1, 16'd5};
    logic exp4 [5] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    logic [15:0] cnt4 [5] = '{16'd4, 16'd3, 16'd2, 16'd1, 16'd4};
    do_load(16'd5, 3'd3, 1'b0);
    for (int i = 0; i < 6; i++) begin
      tick1(); check("R7 odd square wave", cnt5[i], exp5[i]);
    end
    do_load(16'd4, 3'd3, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick1(); check("R7 even square wave", cnt4[i], exp4[i]);
    end
  endtask

  task automatic t_bcd();
    do_load(16'h0100, 3'd0, 1'b1);
    tick1(); check("R4 bcd start", 16'h0100, 1'b0);
    tick1(); check("R4 bcd borrow across digits", 16'h0099, 1'b0);
    tick1(); check("R4 bcd digit decrement", 16'h0098, 1'b0);
    do_load(16'h0000, 3'd0, 1'b1);
    tick1(); check("R4 bcd zero start", 16'h0000, 1'b0);
    tick1(); check("R4 bcd wrap to 9999", 16'h9999, 1'b0);
    bulk(9998); check("R4 bcd near full scale", 16'h0001, 1'b0);
    tick1(); check("R4 bcd full scale tc", 16'h0000, 1'b1);
  endtask

  task automatic t_mode4();
    do_load(16'h0002, 3'd4, 1'b1); check("R9 mode4 high", 16'h0002, 1'b1);
    tick1(); check("R8 start", 16'h0002, 1'b1);
    tick1(); check("R8 high before tc", 16'h0001, 1'b1);
    tick1(); check("R8 low pulse at tc", 16'h0000, 1'b0);
    tick1(); check("R8 pulse ends", 16'h9999, 1'b1);
    bulk(9999); check("R8 no second pulse", 16'h0000, 1'b1);
  endtask

  task automatic t_binary_full();
    do_load(16'h0000, 3'd0, 1'b0);
    tick1(); check("R3 full scale start", 16'h0000, 1'b0);
    bulk(65535); check("R3 one tick left", 16'h0001, 1'b0);
    tick1(); check("R3 full scale tc", 16'h0000, 1'b1);
  endtask

  task automatic t_mode1();
    gate_in = 1'b0;
    do_load(16'd2, 3'd1, 1'b0); check("R9 mode1 high before start", 16'd2, 1'b1);
    tick1(); check("R5 mode1 low once started", 16'd2, 1'b0);
    tick1(); check("R5 mode1 counting with gate low", 16'd1, 1'b0);
    tick1(); check("R5 mode1 tc", 16'd0, 1'b1);
    tick1(); check("R5 mode1 after wrap", 16'hFFFF, 1'b1);
    gate_in = 1'b1;
    tick1(); check("R10 mode1 trigger reloads", 16'd2, 1'b1);
    tick1(); check("R10 mode1 restarted low", 16'd2, 1'b0);
    tick1(); check("R10 mode1 counting", 16'd1, 1'b0);
    tick1(); check("R10 mode1 tc again", 16'd0, 1'b1);
  endtask

  task automatic t_mode5();
    gate_in = 1'b0;
    do_load(16'd4, 3'd5, 1'b0);
    tick1(); check("R8 mode5 start", 16'd4, 1'b1);
    tick1(); check("R8 mode5 count", 16'd3, 1'b1);
    gate_in = 1'b1;
    tick1(); check("R10 mode5 retrigger", 16'd4, 1'b1);
    tick1(); check("R10 mode5 start", 16'd4, 1'b1);
    bulk(3);  check("R8 mode5 before tc", 16'd1, 1'b1);
    tick1(); check("R8 mode5 pulse", 16'd0, 1'b0);
    tick1(); check("R8 mode5 pulse ends", 16'hFFFF, 1'b1);
  endtask

  task automatic t_alias();
    gate_in = 1'b1;
    do_load(16'd2, 3'd6, 1'b0); check("R12 code6 before start", 16'd2, 1'b1);
    tick1(); check("R12 code6 start", 16'd2, 1'b1);
    tick1(); check("R12 code6 low at 1", 16'd1, 1'b0);
    tick1(); check("R12 code6 reload", 16'd2, 1'b1);
    do_load(16'd4, 3'd7, 1'b0);
    tick1(); check("R12 code7 start", 16'd4, 1'b1);
    tick1(); check("R12 code7 high half", 16'd3, 1'b1);
    tick1(); check("R12 code7 low half", 16'd2, 1'b0);
    tick1(); check("R12 code7 low half end", 16'd1, 1'b0);
    tick1(); check("R12 code7 reload", 16'd4, 1'b1);
  endtask

  task automatic t_collide();
    do_load(16'd2, 3'd4, 1'b0);
    tick1(); tick1(); check("R13 setup one before tc", 16'd1, 1'b1);
    @(negedge clk);
    load_stb = 1'b1; load_value = 16'd7; load_mode = 3'd4; tick_en = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; tick_en = 1'b0;
    check("R13 load beats tick, no pulse", 16'd7, 1'b1);
    tick1(); check("R13 start after collision", 16'd7, 1'b1);
    tick1(); check("R13 counts from loaded value", 16'd6, 1'b1);
    gate_in = 1'b0;
    do_load(16'd3, 3'd5, 1'b0);
    tick1(); tick1(); check("R13 mode5 setup", 16'd2, 1'b1);
    @(negedge clk);
    gate_in = 1'b1; load_stb = 1'b1; load_value = 16'd9; load_mode = 3'd5; tick_en = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; tick_en = 1'b0;
    check("R13 load beats gate edge", 16'd9, 1'b1);
    tick1(); check("R13 start after gate collision", 16'd9, 1'b1);
    tick1(); check("R13 counting after gate collision", 16'd8, 1'b1);
  endtask

  initial begin
    #1_900_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_gate_mode0();
    t_mode2();
    t_mode3();
    t_bcd();
    t_mode4();
    t_binary_full();
    t_mode1();
    t_mode5();
    t_alias();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule